// File: doc/BRIEF.md
# Source-Routed Nibble Switch Node

This block is one switching node of a network in which the sender writes the whole path into the head of each packet. A packet is a stream of 4-bit nibbles. The first nibble that reaches a node is that node's route code. The node consumes that nibble and does not forward it. The code selects one of four outgoing links, or the local delivery port of the node. The node then passes the remaining nibbles through as soon as the chosen output is granted to it. It does not wait for the end of the packet.

When the arriving packet ends, the node adds one extra nibble, marked last, that holds the index of the link the packet arrived on. A reply can use that nibble to retrace the hop. Over many hops the return path therefore grows at the tail by one nibble per node. A packet may leave on the link it came in on, which lets a sender measure round-trip latency.

Every port is a valid/ready/last stream. A transfer happens on a rising clock edge where valid and ready are both high. Each output has a round-robin arbiter. A winning input keeps its output until the appended nibble has been accepted.

Each input runs a four-state machine, with state register and outputs in separate processes:
- **IDLE** takes the route nibble and moves to WAIT. This is the *capture* transition.
- **WAIT** moves to FWD on grant (*grant*). If the captured nibble was already last, it moves straight to TAIL instead (*grant-empty*).
- **FWD** moves to TAIL when the last payload nibble is accepted (*end*).
- **TAIL** moves back to IDLE when the appended nibble is accepted (*release*).

Top module: `nibble_route_switch`

## Requirements
- R1: A packet whose first nibble is a code c from 0 to 3 leaves on link output c. That first nibble is removed, and the remaining payload nibbles follow in order with last low.
- R2: A code c from 4 to 15 delivers the packet on the local output, with `loc_port` equal to c for every nibble of that packet.
- R3: After the final payload nibble, the output carries one more nibble with last high, whose value is the arrival link index (0 to 3).
- R4: A packet may leave on the same link number it arrived on.
- R5: A packet made only of a route nibble with last set is still delivered, as a single nibble carrying the arrival index with last high.
- R6: Forwarding is cut-through: payload nibbles appear at the output before the input's last nibble has been accepted.
- R7: Inputs that contend for one output are served in round-robin order: input index after the previous winner first, wrapping around.
- R8: Once granted, an output carries one packet contiguously, up to and including its appended nibble, with no nibbles from another input in between.
- R9: Under output or input stalls, no nibble is lost or repeated, and a stalled output holds its valid, data and last.
- R10: While reset is high and just after it is released, all inputs are ready (idle), and every link output and the local output have valid low.
- R11: An input that has a packet waiting but no grant holds its ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-link input valid |
| in_data | input | 16 | Per-link input nibble, link i in bits [4i+3:4i] |
| in_last | input | 4 | Per-link end of packet |
| in_ready | output | 4 | Per-link input ready |
| out_valid | output | 4 | Per-link output valid |
| out_data | output | 16 | Per-link output nibble, link i in bits [4i+3:4i] |
| out_last | output | 4 | Per-link output end of packet |
| out_ready | input | 4 | Per-link output ready |
| loc_valid | output | 1 | Local delivery valid |
| loc_data | output | 4 | Local delivery nibble |
| loc_last | output | 1 | Local delivery end of packet |
| loc_port | output | 4 | Local port code taken from the route nibble |
| loc_ready | input | 1 | Local delivery ready |

## Verification
The stall-hold assertion on the outputs assumes that each upstream sender behaves as a stream source. Once it raises valid, it keeps valid, data and last steady until the nibble is accepted. The stimulus meets this: a nibble is presented from a queue head that changes only on a transfer, and an input gap is inserted only while valid is low. No other constraint is placed on inputs. Output ready may toggle on any cycle, and the sweeps run both with ready always high and with a stalling pattern.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
    typedef enum logic [1:0] {
        ING_IDLE,
        ING_WAIT,
        ING_FWD,
        ING_TAIL
    } ing_state_t;
endpackage

// File: rtl/nrs_rr_arbiter.sv
module nrs_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         done,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          owner_v;
    logic [IW-1:0] owner;
    logic [IW-1:0] ptr;
    logic          found;
    logic [IW-1:0] pick;

    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int off = 1; off <= N; off++) begin
            idx = (int'(ptr) + off) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_v <= 1'b0;
            owner   <= '0;
            ptr     <= IW'(N - 1);
        end else if (owner_v && done) begin
            owner_v <= 1'b0;
        end else if (!owner_v && found) begin
            owner_v <= 1'b1;
            owner   <= pick;
            ptr     <= pick;
        end
    end

    always_comb begin
        gnt = '0;
        if (owner_v) gnt[owner] = 1'b1;
    end

    // R8: an owner keeps the output until its tail nibble is accepted
    a_r8_grant_held: assert property (@(posedge clk) disable iff (rst)
        (owner_v && !done) |=> (owner_v && $stable(owner)));

    // R8: release only comes from the current owner
    a_r8_done_from_owner: assert property (@(posedge clk) disable iff (rst)
        done |-> owner_v);

    // R7: a free output with pending requests is granted on the next cycle
    a_r7_no_idle_with_request: assert property (@(posedge clk) disable iff (rst)
        (!owner_v && (|req)) |=> owner_v);
endmodule

// File: rtl/nrs_ingress.sv
module nrs_ingress
    import nrs_pkg::*;
#(
    parameter int NW  = 4,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [NW-1:0] in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic [NW-1:0] route,
    output logic          req,
    input  logic          granted,
    output logic          fwd_valid,
    output logic [NW-1:0] fwd_data,
    output logic          fwd_last,
    input  logic          fwd_ready,
    output logic          done
);
    ing_state_t    state_q, state_d;
    logic [NW-1:0] route_q;
    logic          empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ING_IDLE;
            route_q <= '0;
            empty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ING_IDLE && in_valid) begin
                route_q <= in_data;
                empty_q <= in_last;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ING_IDLE: if (in_valid) state_d = ING_WAIT;
            ING_WAIT: if (granted) state_d = empty_q ? ING_TAIL : ING_FWD;
            ING_FWD:  if (in_valid && fwd_ready && in_last) state_d = ING_TAIL;
            ING_TAIL: if (fwd_ready) state_d = ING_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        fwd_valid = 1'b0;
        fwd_data  = '0;
        fwd_last  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ING_IDLE: in_ready = 1'b1;
            ING_WAIT: in_ready = 1'b0;
            ING_FWD: begin
                fwd_valid = in_valid;
                fwd_data  = in_data;
                in_ready  = fwd_ready;
            end
            ING_TAIL: begin
                fwd_valid = 1'b1;
                fwd_data  = NW'(IDX);
                fwd_last  = 1'b1;
                done      = fwd_ready;
            end
        endcase
    end

    assign route = route_q;
    assign req   = (state_q != ING_IDLE);

    // R3: the accepted last payload nibble is followed by the arrival index
    a_r3_tail_follows_last: assert property (@(posedge clk) disable iff (rst)
        (state_q == ING_FWD && in_valid && fwd_ready && in_last)
        |=> (fwd_valid && fwd_last && fwd_data == NW'(IDX)));

    // R8: forwarding and tail only happen under a grant from the arbiter
    a_r8_sending_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (state_q == ING_FWD || state_q == ING_TAIL) |-> granted);

    // R11: an input with a captured route and no grant takes nothing more
    a_r11_stall_without_grant: assert property (@(posedge clk) disable iff (rst)
        (req && !granted) |-> !in_ready);
endmodule

// File: rtl/nibble_route_switch.sv
module nibble_route_switch #(
    parameter int NLINK = 4,
    parameter int NW    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NLINK-1:0]    in_valid,
    input  logic [NLINK*NW-1:0] in_data,
    input  logic [NLINK-1:0]    in_last,
    output logic [NLINK-1:0]    in_ready,
    output logic [NLINK-1:0]    out_valid,
    output logic [NLINK*NW-1:0] out_data,
    output logic [NLINK-1:0]    out_last,
    input  logic [NLINK-1:0]    out_ready,
    output logic                loc_valid,
    output logic [NW-1:0]       loc_data,
    output logic                loc_last,
    output logic [NW-1:0]       loc_port,
    input  logic                loc_ready
);
    localparam int NT = NLINK + 1;
    localparam int TW = $clog2(NT);
    localparam int LOC = NLINK;

    logic [NW-1:0]    route   [NLINK];
    logic [TW-1:0]    tgt     [NLINK];
    logic [NLINK-1:0] req_any;
    logic [NLINK-1:0] granted;
    logic [NLINK-1:0] fwd_valid, fwd_last, fwd_ready, done_v;
    logic [NW-1:0]    fwd_data [NLINK];
    logic [NLINK-1:0] gnt     [NT];
    logic [NLINK-1:0] treq    [NT];
    logic [NT-1:0]    t_done, t_valid, t_last, t_ready;
    logic [NW-1:0]    t_data  [NT];

    assign t_ready = {loc_ready, out_ready};

    generate
        for (genvar i = 0; i < NLINK; i++) begin : g_in
            nrs_ingress #(.NW(NW), .IDX(i)) u_ing (
                .clk      (clk),
                .rst      (rst),
                .in_valid (in_valid[i]),
                .in_data  (in_data[i*NW +: NW]),
                .in_last  (in_last[i]),
                .in_ready (in_ready[i]),
                .route    (route[i]),
                .req      (req_any[i]),
                .granted  (granted[i]),
                .fwd_valid(fwd_valid[i]),
                .fwd_data (fwd_data[i]),
                .fwd_last (fwd_last[i]),
                .fwd_ready(fwd_ready[i]),
                .done     (done_v[i])
            );

            assign tgt[i] = (int'(route[i]) < NLINK) ? TW'(route[i]) : TW'(LOC);

            logic [NT-1:0] gcol;
            always_comb begin
                for (int t = 0; t < NT; t++) gcol[t] = gnt[t][i];
            end
            assign granted[i]   = |gcol;
            assign fwd_ready[i] = granted[i] & t_ready[tgt[i]];

            // R8: an input holds a grant from at most one output at a time
            a_r8_one_output_per_input: assert property (@(posedge clk) disable iff (rst)
                $onehot0(gcol));
        end

        for (genvar t = 0; t < NT; t++) begin : g_out
            always_comb begin
                for (int i = 0; i < NLINK; i++) treq[t][i] = req_any[i] && (int'(tgt[i]) == t);
            end

            nrs_rr_arbiter #(.N(NLINK)) u_arb (
                .clk (clk),
                .rst (rst),
                .req (treq[t]),
                .done(t_done[t]),
                .gnt (gnt[t])
            );

            always_comb begin
                t_done[t]  = |(gnt[t] & done_v);
                t_valid[t] = |(gnt[t] & fwd_valid);
                t_last[t]  = |(gnt[t] & fwd_last);
                t_data[t]  = '0;
                for (int i = 0; i < NLINK; i++)
                    if (gnt[t][i]) t_data[t] = t_data[t] | fwd_data[i];
            end

            // R9: a stalled output holds its nibble (inputs hold while stalled)
            a_r9_hold_under_backpressure: assert property (@(posedge clk) disable iff (rst)
                (t_valid[t] && !t_ready[t]) |=> (t_valid[t] && $stable(t_data[t]) && $stable(t_last[t])));
        end

        for (genvar o = 0; o < NLINK; o++) begin : g_link
            assign out_valid[o]          = t_valid[o];
            assign out_data[o*NW +: NW]  = t_data[o];
            assign out_last[o]           = t_last[o];
        end
    endgenerate

    always_comb begin
        loc_port = '0;
        for (int i = 0; i < NLINK; i++)
            if (gnt[LOC][i]) loc_port = loc_port | route[i];
    end

    assign loc_valid = t_valid[LOC];
    assign loc_data  = t_data[LOC];
    assign loc_last  = t_last[LOC];

    // R2: local delivery only carries local port codes
    a_r2_local_code_range: assert property (@(posedge clk) disable iff (rst)
        loc_valid |-> (int'(loc_port) >= NLINK));

    // R10: nothing is presented in the cycle right after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (out_valid == '0 && !loc_valid));
endmodule

// File: tb/test_nibble_route_switch.sv
`timescale 1ns/1ps
module test_nibble_route_switch;
    localparam int NL = 4;
    localparam int NT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    in_valid = '0;
    logic [15:0]   in_data  = '0;
    logic [3:0]    in_last  = '0;
    logic [3:0]    in_ready;
    logic [3:0]    out_valid;
    logic [15:0]   out_data;
    logic [3:0]    out_last;
    logic [3:0]    out_ready = '1;
    logic          loc_valid, loc_last, loc_ready = 1'b1;
    logic [3:0]    loc_data, loc_port;

    nibble_route_switch i_nibble_route_switch (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .loc_valid(loc_valid), .loc_data(loc_data), .loc_last(loc_last),
        .loc_port(loc_port), .loc_ready(loc_ready)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic rdy_mode = 1'b0;
    logic gap_mode = 1'b0;

    logic [4:0] txb [NL][64];
    int         txh [NL];
    int         txt [NL];
    logic [8:0] rxb [NT][128];
    int         rxn [NT];
    logic [8:0] exb [NT][128];
    int         exn [NT];
    int         first_rx_cyc [NT];
    int         last_tx_cyc  [NL];
    logic [NL-1:0] stall_seen;

    task automatic clear_bufs();
        for (int i = 0; i < NL; i++) begin txh[i] = 0; txt[i] = 0; last_tx_cyc[i] = -1; end
        for (int o = 0; o < NT; o++) begin rxn[o] = 0; exn[o] = 0; first_rx_cyc[o] = -1; end
        stall_seen = '0;
    endtask

    always begin
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            if (txh[i] < txt[i] && (in_valid[i] || !gap_mode || ((cyc + i) % 3 != 0))) begin
                in_valid[i]       = 1'b1;
                in_data[i*4 +: 4] = txb[i][txh[i]][3:0];
                in_last[i]        = txb[i][txh[i]][4];
            end else begin
                in_valid[i] = 1'b0;
                in_last[i]  = 1'b0;
            end
        end
        for (int o = 0; o < NL; o++) out_ready[o] = !rdy_mode || ((cyc * 3 + o) % 4 != 0);
        loc_ready = !rdy_mode || ((cyc * 3 + 4) % 4 != 1);
        #4;
        if (!rst) begin
            for (int i = 0; i < NL; i++) begin
                if (in_valid[i] && !in_ready[i]) stall_seen[i] = 1'b1;
                if (in_valid[i] && in_ready[i]) begin
                    if (in_last[i]) last_tx_cyc[i] = cyc;
                    txh[i]++;
                end
            end
            for (int o = 0; o < NL; o++) begin
                if (out_valid[o] && out_ready[o] && rxn[o] < 128) begin
                    if (first_rx_cyc[o] < 0) first_rx_cyc[o] = cyc;
                    rxb[o][rxn[o]] = {4'd0, out_last[o], out_data[o*4 +: 4]};
                    rxn[o]++;
                end
            end
            if (loc_valid && loc_ready && rxn[4] < 128) begin
                if (first_rx_cyc[4] < 0) first_rx_cyc[4] = cyc;
                rxb[4][rxn[4]] = {loc_port, loc_last, loc_data};
                rxn[4]++;
            end
        end
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d (actual running, expected finished)", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] nib(input int s, input int c, input int k);
        return 4'((s * 5 + c + 3 * k + 7 * k * k) & 15);
    endfunction

    // Queue a packet from input s with route code c and len payload nibbles;
    // optionally record the expected output stream.
    task automatic push_pkt(input int s, input int c, input int len, input bit add_exp);
        int t;
        t = (c < NL) ? c : 4;
        txb[s][txt[s]] = {len == 0, 4'(c)};
        txt[s]++;
        for (int k = 0; k < len; k++) begin
            txb[s][txt[s]] = {k == len - 1, nib(s, c, k)};
            txt[s]++;
            if (add_exp) begin
                exb[t][exn[t]] = {(t == 4) ? 4'(c) : 4'd0, 1'b0, nib(s, c, k)};
                exn[t]++;
            end
        end
        if (add_exp) begin
            exb[t][exn[t]] = {(t == 4) ? 4'(c) : 4'd0, 1'b1, 4'(s)};
            exn[t]++;
        end
    endtask

    task automatic wait_drain();
        bit busy;
        int guard;
        guard = 0;
        do begin
            @(posedge clk);
            guard++;
            busy = 1'b0;
            for (int i = 0; i < NL; i++) if (txh[i] < txt[i]) busy = 1'b1;
            for (int o = 0; o < NT; o++) if (rxn[o] < exn[o]) busy = 1'b1;
        end while (busy && guard < 3000);
        repeat (4) @(posedge clk);
    endtask

    // Compare the whole of output t with its expectation.
    task automatic cmp_stream(input int t, input string tag);
        int bad;
        bad = -1;
        for (int k = 0; k < exn[t]; k++)
            if (bad < 0 && (k >= rxn[t] || rxb[t][k] !== exb[t][k])) bad = k;
        if (bad >= 0)
            check(1'b0, tag, (bad < rxn[t]) ? int'(rxb[t][bad]) : -1, int'(exb[t][bad]));
        else
            check(rxn[t] == exn[t], tag, rxn[t], exn[t]);
    endtask

    initial begin
        clear_bufs();
        repeat (4) @(posedge clk);
        @(negedge clk); #2;
        // R10: idle state visible during reset
        check(in_ready == 4'hF, "R10 in_ready in reset", int'(in_ready), 15);
        rst = 1'b0;
        @(negedge clk); #2;
        check(in_ready == 4'hF, "R10 in_ready after reset", int'(in_ready), 15);
        check(out_valid == 4'h0, "R10 out_valid after reset", int'(out_valid), 0);
        check(loc_valid == 1'b0, "R10 loc_valid after reset", int'(loc_valid), 0);

        // Sweep every (source, code) pair, once free-running and once stalled.
        for (int pass = 0; pass < 2; pass++) begin
            rdy_mode = pass[0];
            gap_mode = pass[0];
            for (int s = 0; s < NL; s++) begin
                for (int c = 0; c < 16; c++) begin
                    int len, t;
                    string tag;
                    len = (s + c + pass) % 4;
                    t = (c < NL) ? c : 4;
                    clear_bufs();
                    push_pkt(s, c, len, 1'b1);
                    wait_drain();
                    if (len == 0)       tag = "R5 route-only packet";
                    else if (c == s)    tag = "R4 same-link return";
                    else if (c >= NL)   tag = "R2 local delivery";
                    else if (pass == 1) tag = "R9 stalled link packet";
                    else                tag = "R1 link packet";
                    cmp_stream(t, tag);
                    // R3: final nibble is the arrival index with last
                    check(rxn[t] > 0 && rxb[t][rxn[t]-1][4:0] == {1'b1, 4'(s)},
                          "R3 appended arrival nibble",
                          (rxn[t] > 0) ? int'(rxb[t][rxn[t]-1][4:0]) : -1, 16 + s);
                    // R1: nothing on any other output
                    for (int o = 0; o < NT; o++)
                        if (o != t) check(rxn[o] == 0, "R1 no stray output", rxn[o], 0);
                end
            end
        end

        // R6: cut-through, long packet on link 0 to link 2
        rdy_mode = 1'b0; gap_mode = 1'b0;
        clear_bufs();
        push_pkt(0, 2, 14, 1'b1);
        wait_drain();
        cmp_stream(2, "R6 long packet stream");
        check(first_rx_cyc[2] >= 0 && first_rx_cyc[2] < last_tx_cyc[0],
              "R6 output starts before input last", first_rx_cyc[2], last_tx_cyc[0]);

        // R7/R8/R11: three inputs contend for link 3, two packets each.
        for (int pass = 0; pass < 2; pass++) begin
            rdy_mode = pass[0];
            clear_bufs();
            for (int s = 0; s < 3; s++) begin
                push_pkt(s, 3, 3, 1'b0);
                push_pkt(s, 3, 3, 1'b0);
            end
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 3; s++) begin
                    for (int k = 0; k < 3; k++) begin
                        exb[3][exn[3]] = {4'd0, 1'b0, nib(s, 3, k)};
                        exn[3]++;
                    end
                    exb[3][exn[3]] = {4'd0, 1'b1, 4'(s)};
                    exn[3]++;
                end
            wait_drain();
            cmp_stream(3, "R7 round-robin order");
            cmp_stream(3, "R8 contiguous packets");
            check(stall_seen[1] && stall_seen[2], "R11 losers stalled",
                  int'(stall_seen), 7);
        end

        // R4 with concurrency: all four links ping back to themselves at once.
        rdy_mode = 1'b1;
        clear_bufs();
        for (int s = 0; s < NL; s++) push_pkt(s, s, 2 + s, 1'b1);
        wait_drain();
        for (int s = 0; s < NL; s++) cmp_stream(s, "R4 concurrent self-return");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule